// File: doc/BRIEF.md
# Integer Execution Unit for a Load/Store Core

This block is the integer arithmetic and logic stage of a 32-bit load/store processor that uses three-address instructions. It is purely combinational. It takes a first source operand and a second source, selected per instruction from a register value or from a 16-bit immediate, together with an operation code. It returns one 32-bit result that is written back to a general register.

The core has no flag register, so nothing here updates status bits. A relational test yields 0 or 1 in the result word. The upper half of a register is loaded from a dedicated immediate path. The only side output is an overflow indication for the signed add and subtract forms. A trap stage downstream may use it or ignore it.

Top module: `int_exec_alu`

## Requirements
- R1: Operation codes 0 (add), 1 (unsigned add), 2 (subtract) and 3 (unsigned subtract) return opa + B or opa - B modulo 2^32, where B is the selected second operand.
- R2: With use_imm = 1, B is the 16-bit immediate extended to 32 bits. It is sign-extended for codes 0, 2 and 11 to 16. It is zero-extended for codes 1, 3, 4, 5 and 6. With use_imm = 0, B is opb_reg.
- R3: ovf_flag is 1 only for codes 0 and 2, and only when the true two's-complement result does not fit in 32 bits. It is 0 for every other code.
- R4: Codes 4, 5 and 6 return the bitwise AND, OR and XOR of opa and B.
- R5: Codes 7, 8 and 9 shift opa left with zero fill, right with zero fill, and right with sign fill, respectively. The distance is B[4:0], and the higher bits of B have no effect.
- R6: Code 10 returns imm in bits 31:16 and zeros in bits 15:0, for any value of opa, opb_reg or use_imm.
- R7: Codes 11 to 16 compare opa with B as signed two's-complement numbers, testing less-than, greater-than, less-or-equal, greater-or-equal, equal and not-equal in that order. The result is 1 when the relation holds and 0 otherwise.
- R8: Codes 17 to 31 are unassigned. They return a result of 0 with ovf_flag 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 5 | Operation code |
| opa | input | 32 | First source operand |
| opb_reg | input | 32 | Second source when the register form is used |
| imm | input | 16 | Immediate field of the instruction |
| use_imm | input | 1 | Selects the extended immediate as second source |
| result | output | 32 | Value for the destination register |
| ovf_flag | output | 1 | Signed add/subtract overflow |

## Verification
The embedded assertions test several properties whenever the inputs change. Overflow never appears on an unsigned or non-arithmetic code. An overflowing add always has sources of equal sign. A set result never uses more than bit 0. The low half of a load-high result is always empty. A logical right shift by a nonzero distance never leaves the top bit set. Unassigned codes stay silent. Only the directed scenarios can show that each value is correct: the wrap-around sums, the choice between sign and zero extension of the immediate, the masking of the shift distance, and the signed ordering of the compares at the boundary between negative and positive values.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;
   localparam int OPW = 5;

   typedef enum logic [OPW-1:0] {
      OP_ADD  = 5'd0,
      OP_ADDU = 5'd1,
      OP_SUB  = 5'd2,
      OP_SUBU = 5'd3,
      OP_AND  = 5'd4,
      OP_OR   = 5'd5,
      OP_XOR  = 5'd6,
      OP_SLL  = 5'd7,
      OP_SRL  = 5'd8,
      OP_SRA  = 5'd9,
      OP_LHI  = 5'd10,
      OP_SLT  = 5'd11,
      OP_SGT  = 5'd12,
      OP_SLE  = 5'd13,
      OP_SGE  = 5'd14,
      OP_SEQ  = 5'd15,
      OP_SNE  = 5'd16
   } alu_op_e;

   typedef enum logic [1:0] {
      SH_LEFT  = 2'd0,
      SH_RLOG  = 2'd1,
      SH_RARI  = 2'd2,
      SH_NONE  = 2'd3
   } shift_kind_e;

   typedef enum logic [2:0] {
      REL_LT = 3'd0,
      REL_GT = 3'd1,
      REL_LE = 3'd2,
      REL_GE = 3'd3,
      REL_EQ = 3'd4,
      REL_NE = 3'd5
   } rel_e;
endpackage

// File: rtl/alu_imm_ext.sv
module alu_imm_ext #(
   parameter int WIDTH = 32,
   parameter int IMM_W = 16
) (
   input  logic [IMM_W-1:0] imm,
   input  logic             sext,
   output logic [WIDTH-1:0] ext
);
   localparam int PAD = WIDTH - IMM_W;

   generate
      if (PAD > 0) begin : g_pad
         assign ext = {{PAD{sext & imm[IMM_W-1]}}, imm};
      end else begin : g_nopad
         assign ext = imm[WIDTH-1:0];
      end
   endgenerate

   // R2: a zero-extended immediate never carries bits above the field
   always_comb begin
      if (PAD > 0 && !sext)
         p_zero_fill_r2: assert (ext >> IMM_W == '0);
   end
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             sub,
   input  logic             chk_ovf,
   output logic [WIDTH-1:0] res,
   output logic             ovf
);
   localparam int M = WIDTH - 1;

   logic [WIDTH-1:0] b_eff;

   always_comb begin
      b_eff = sub ? ~b : b;
      res   = a + b_eff + {{(WIDTH-1){1'b0}}, sub};
      ovf   = chk_ovf & (a[M] == b_eff[M]) & (res[M] != a[M]);
   end

   // R3: an add overflows only with equal-signed sources, a subtract only with unequal ones
   always_comb begin
      p_add_sign_r3: assert (!(ovf && !sub && (a[M] != b[M])));
      p_sub_sign_r3: assert (!(ovf && sub && (a[M] == b[M])));
   end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter
   import int_alu_pkg::*;
#(
   parameter int WIDTH = 32,
   parameter int SHW   = $clog2(WIDTH)
) (
   input  logic [WIDTH-1:0] a,
   input  logic [SHW-1:0]   amt,
   input  shift_kind_e      kind,
   output logic [WIDTH-1:0] res
);
   always_comb begin
      case (kind)
         SH_LEFT: res = a << amt;
         SH_RLOG: res = a >> amt;
         SH_RARI: res = $unsigned($signed(a) >>> amt);
         default: res = '0;
      endcase
   end

   // R5: zero fill from the left empties the top bit for any nonzero distance
   always_comb begin
      p_srl_fill_r5: assert (!(kind == SH_RLOG && amt != '0 && res[WIDTH-1]));
   end
endmodule

// File: rtl/alu_compare.sv
module alu_compare
   import int_alu_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  rel_e             rel,
   output logic             hit
);
   logic lt, eq;

   always_comb begin
      lt = $signed(a) < $signed(b);
      eq = (a == b);
      case (rel)
         REL_LT:  hit = lt;
         REL_GT:  hit = !lt && !eq;
         REL_LE:  hit = lt || eq;
         REL_GE:  hit = !lt;
         REL_EQ:  hit = eq;
         REL_NE:  hit = !eq;
         default: hit = 1'b0;
      endcase
   end

   // R7: less-than and equality never hold together
   always_comb begin
      p_order_r7: assert (!(lt && eq));
   end
endmodule

// File: rtl/int_exec_alu.sv
module int_exec_alu
   import int_alu_pkg::*;
#(
   parameter int WIDTH = 32,
   parameter int IMM_W = 16
) (
   input  logic [4:0]       op_sel,
   input  logic [31:0]      opa,
   input  logic [31:0]      opb_reg,
   input  logic [15:0]      imm,
   input  logic             use_imm,
   output logic [31:0]      result,
   output logic             ovf_flag
);
   localparam int SHW = $clog2(WIDTH);
   localparam int LOW = WIDTH - IMM_W;

   generate
      if (WIDTH != 32 || IMM_W != 16) begin : g_bad_port
         $error("int_exec_alu: ports are fixed at 32-bit data and 16-bit immediate");
      end
      if ((1 << SHW) != WIDTH) begin : g_bad_pow
         $error("int_exec_alu: WIDTH must be a power of two");
      end
      if (LOW < 1) begin : g_bad_imm
         $error("int_exec_alu: IMM_W must be narrower than WIDTH");
      end
   endgenerate

   logic             sext, sub, chk_ovf, rel_op;
   shift_kind_e      kind;
   rel_e             rel;
   logic [WIDTH-1:0] b_ext, b_op, sum, shres, lhi_val;
   logic             sum_ovf, hit;

   always_comb begin
      sext    = 1'b0;
      sub     = 1'b0;
      chk_ovf = 1'b0;
      rel_op  = 1'b0;
      kind    = SH_NONE;
      rel     = REL_LT;
      case (op_sel)
         OP_ADD:  begin sext = 1'b1; chk_ovf = 1'b1; end
         OP_SUB:  begin sext = 1'b1; chk_ovf = 1'b1; sub = 1'b1; end
         OP_SUBU: sub = 1'b1;
         OP_SLL:  kind = SH_LEFT;
         OP_SRL:  kind = SH_RLOG;
         OP_SRA:  kind = SH_RARI;
         OP_SLT:  begin sext = 1'b1; rel_op = 1'b1; rel = REL_LT; end
         OP_SGT:  begin sext = 1'b1; rel_op = 1'b1; rel = REL_GT; end
         OP_SLE:  begin sext = 1'b1; rel_op = 1'b1; rel = REL_LE; end
         OP_SGE:  begin sext = 1'b1; rel_op = 1'b1; rel = REL_GE; end
         OP_SEQ:  begin sext = 1'b1; rel_op = 1'b1; rel = REL_EQ; end
         OP_SNE:  begin sext = 1'b1; rel_op = 1'b1; rel = REL_NE; end
         default: ;
      endcase
   end

   alu_imm_ext #(.WIDTH(WIDTH), .IMM_W(IMM_W)) u_ext (
      .imm  (imm),
      .sext (sext),
      .ext  (b_ext)
   );

   assign b_op    = use_imm ? b_ext : opb_reg;
   assign lhi_val = {imm, {LOW{1'b0}}};

   alu_addsub #(.WIDTH(WIDTH)) u_add (
      .a       (opa),
      .b       (b_op),
      .sub     (sub),
      .chk_ovf (chk_ovf),
      .res     (sum),
      .ovf     (sum_ovf)
   );

   alu_shifter #(.WIDTH(WIDTH), .SHW(SHW)) u_shf (
      .a    (opa),
      .amt  (b_op[SHW-1:0]),
      .kind (kind),
      .res  (shres)
   );

   alu_compare #(.WIDTH(WIDTH)) u_cmp (
      .a   (opa),
      .b   (b_op),
      .rel (rel),
      .hit (hit)
   );

   always_comb begin
      result   = '0;
      ovf_flag = sum_ovf;
      case (op_sel)
         OP_ADD, OP_ADDU, OP_SUB, OP_SUBU: result = sum;
         OP_AND:                           result = opa & b_op;
         OP_OR:                            result = opa | b_op;
         OP_XOR:                           result = opa ^ b_op;
         OP_SLL, OP_SRL, OP_SRA:           result = shres;
         OP_LHI:                           result = lhi_val;
         default:                          result = {{(WIDTH-1){1'b0}}, rel_op & hit};
      endcase
   end

   // R3: only the signed add and subtract codes may raise overflow
   always_comb begin
      p_no_overflow_r3: assert (!(ovf_flag && op_sel != OP_ADD && op_sel != OP_SUB));
   end

   // R7: a set code writes nothing above bit 0
   always_comb begin
      if (op_sel >= OP_SLT && op_sel <= OP_SNE)
         p_set_bool_r7: assert (result[WIDTH-1:1] == '0);
   end

   // R6: load-high leaves the low half empty
   always_comb begin
      if (op_sel == OP_LHI)
         p_lhi_low_r6: assert (result[LOW-1:0] == '0);
   end

   // R8: unassigned codes produce nothing
   always_comb begin
      if (op_sel > OP_SNE)
         p_undef_quiet_r8: assert (result == '0 && !ovf_flag);
   end
endmodule

// File: tb/int_exec_alu_test.sv
module int_exec_alu_test;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [4:0]  op_sel = '0;
   logic [31:0] opa = '0;
   logic [31:0] opb_reg = '0;
   logic [15:0] imm = '0;
   logic        use_imm = 1'b0;
   logic [31:0] result;
   logic        ovf_flag;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   always #4 clk = ~clk;

   int_exec_alu uut (
      .op_sel   (op_sel),
      .opa      (opa),
      .opb_reg  (opb_reg),
      .imm      (imm),
      .use_imm  (use_imm),
      .result   (result),
      .ovf_flag (ovf_flag)
   );

   task automatic drive(input logic [4:0] op, input logic [31:0] a,
                        input logic [31:0] b, input logic [15:0] im, input logic ui);
      @(posedge clk);
      #1;
      op_sel = op; opa = a; opb_reg = b; imm = im; use_imm = ui;
      @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [31:0] got_r, input logic [31:0] exp_r,
                      input logic got_o, input logic exp_o);
      total++;
      if (got_r !== exp_r || got_o !== exp_o) begin
         bad++;
         $display("FAIL %s: result=%h ovf=%b expected result=%h ovf=%b",
                  tag, got_r, got_o, exp_r, exp_o);
      end
   endtask

   task automatic t_reset;
      @(negedge clk);
      chk("R1 idle zero add", result, 32'h0, ovf_flag, 1'b0);
   endtask

   task automatic t_arith;
      drive(5'd0, 32'd100, 32'd23, 16'h0, 1'b0);
      chk("R1 add", result, 32'd123, ovf_flag, 1'b0);
      drive(5'd1, 32'hFFFF_FFFF, 32'd2, 16'h0, 1'b0);
      chk("R1 addu wrap", result, 32'd1, ovf_flag, 1'b0);
      drive(5'd3, 32'd5, 32'd7, 16'h0, 1'b0);
      chk("R1 subu borrow", result, 32'hFFFF_FFFE, ovf_flag, 1'b0);
   endtask

   task automatic t_ovf;
      drive(5'd0, 32'h7FFF_FFFF, 32'd1, 16'h0, 1'b0);
      chk("R3 add overflow", result, 32'h8000_0000, ovf_flag, 1'b1);
      drive(5'd1, 32'h7FFF_FFFF, 32'd1, 16'h0, 1'b0);
      chk("R3 addu no flag", result, 32'h8000_0000, ovf_flag, 1'b0);
      drive(5'd2, 32'h8000_0000, 32'd1, 16'h0, 1'b0);
      chk("R3 sub overflow", result, 32'h7FFF_FFFF, ovf_flag, 1'b1);
      drive(5'd2, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 16'h0, 1'b0);
      chk("R3 sub no overflow", result, 32'h8000_0000, ovf_flag, 1'b0);
      drive(5'd0, 32'h8000_0000, 32'h8000_0000, 16'h0, 1'b0);
      chk("R3 add negative overflow", result, 32'h0, ovf_flag, 1'b1);
   endtask

   task automatic t_imm_ext;
      drive(5'd0, 32'd10, 32'hDEAD_BEEF, 16'hFFFF, 1'b1);
      chk("R2 add imm sign", result, 32'd9, ovf_flag, 1'b0);
      drive(5'd1, 32'd10, 32'hDEAD_BEEF, 16'hFFFF, 1'b1);
      chk("R2 addu imm zero", result, 32'h0001_0009, ovf_flag, 1'b0);
      drive(5'd2, 32'd0, 32'h0, 16'h8000, 1'b1);
      chk("R2 sub imm sign", result, 32'h0000_8000, ovf_flag, 1'b0);
      drive(5'd4, 32'hFFFF_FFFF, 32'h0, 16'hFF00, 1'b1);
      chk("R2 and imm zero", result, 32'h0000_FF00, ovf_flag, 1'b0);
      drive(5'd11, 32'd0, 32'd5, 16'hFFFF, 1'b1);
      chk("R2 slt imm sign", result, 32'd0, ovf_flag, 1'b0);
   endtask

   task automatic t_logic;
      drive(5'd4, 32'hF0F0_1234, 32'h0FF0_FF00, 16'h0, 1'b0);
      chk("R4 and", result, 32'h00F0_1200, ovf_flag, 1'b0);
      drive(5'd5, 32'hF000_000F, 32'h0F00_00F0, 16'h0, 1'b0);
      chk("R4 or", result, 32'hFF00_00FF, ovf_flag, 1'b0);
      drive(5'd6, 32'hAAAA_5555, 32'hFFFF_0000, 16'h0, 1'b0);
      chk("R4 xor", result, 32'h5555_5555, ovf_flag, 1'b0);
      drive(5'd5, 32'h1234_0000, 32'h0, 16'h8001, 1'b1);
      chk("R4 or imm", result, 32'h1234_8001, ovf_flag, 1'b0);
   endtask

   task automatic t_shift;
      drive(5'd7, 32'd1, 32'h0000_0024, 16'h0, 1'b0);
      chk("R5 sll masked distance", result, 32'h0000_0010, ovf_flag, 1'b0);
      drive(5'd8, 32'h8000_0000, 32'd31, 16'h0, 1'b0);
      chk("R5 srl", result, 32'd1, ovf_flag, 1'b0);
      drive(5'd9, 32'h8000_0000, 32'd4, 16'h0, 1'b0);
      chk("R5 sra sign fill", result, 32'hF800_0000, ovf_flag, 1'b0);
      drive(5'd9, 32'h4000_0000, 32'hFFFF_FFE1, 16'h0, 1'b0);
      chk("R5 sra positive masked", result, 32'h2000_0000, ovf_flag, 1'b0);
      drive(5'd7, 32'h0000_00FF, 32'h0, 16'h0028, 1'b1);
      chk("R5 sll imm distance", result, 32'h0000_FF00, ovf_flag, 1'b0);
   endtask

   task automatic t_lhi;
      drive(5'd10, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'h1234, 1'b0);
      chk("R6 lhi reg form", result, 32'h1234_0000, ovf_flag, 1'b0);
      drive(5'd10, 32'h5555_5555, 32'h0, 16'hABCD, 1'b1);
      chk("R6 lhi imm form", result, 32'hABCD_0000, ovf_flag, 1'b0);
   endtask

   task automatic t_compare;
      drive(5'd11, 32'hFFFF_FFFF, 32'd1, 16'h0, 1'b0);
      chk("R7 slt signed", result, 32'd1, ovf_flag, 1'b0);
      drive(5'd12, 32'd1, 32'hFFFF_FFFF, 16'h0, 1'b0);
      chk("R7 sgt signed", result, 32'd1, ovf_flag, 1'b0);
      drive(5'd13, 32'd42, 32'd42, 16'h0, 1'b0);
      chk("R7 sle equal", result, 32'd1, ovf_flag, 1'b0);
      drive(5'd14, 32'hFFFF_FFFB, 32'd3, 16'h0, 1'b0);
      chk("R7 sge false", result, 32'd0, ovf_flag, 1'b0);
      drive(5'd15, 32'd7, 32'd8, 16'h0, 1'b0);
      chk("R7 seq false", result, 32'd0, ovf_flag, 1'b0);
      drive(5'd16, 32'd7, 32'd8, 16'h0, 1'b0);
      chk("R7 sne true", result, 32'd1, ovf_flag, 1'b0);
      drive(5'd11, 32'h8000_0000, 32'h7FFF_FFFF, 16'h0, 1'b0);
      chk("R7 slt extremes", result, 32'd1, ovf_flag, 1'b0);
      drive(5'd15, 32'hFFFF_FFFF, 32'h0, 16'hFFFF, 1'b1);
      chk("R7 seq imm", result, 32'd1, ovf_flag, 1'b0);
   endtask

   task automatic t_undef;
      drive(5'd17, 32'h7FFF_FFFF, 32'd1, 16'hFFFF, 1'b0);
      chk("R8 code 17", result, 32'd0, ovf_flag, 1'b0);
      drive(5'd31, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hFFFF, 1'b1);
      chk("R8 code 31", result, 32'd0, ovf_flag, 1'b0);
   endtask

   initial begin
      repeat (2) @(posedge clk);
      rst = 1'b0;
      t_reset;
      t_arith;
      t_ovf;
      t_imm_ext;
      t_logic;
      t_shift;
      t_lhi;
      t_compare;
      t_undef;
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule